// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Set-Less-Than

This block is an integer arithmetic and logic unit built from a chain of identical one-bit slices. Each slice forms the AND, the OR and the full-adder sum of its operand bits at the same time. A per-slice selector then picks one of them or a comparison input. Carries pass from each slice to the next one up. Subtraction reuses the adder by inverting the second operand and forcing the first carry in to one. Inverting both operands turns the AND path into a NOR.

Signed set-less-than reuses the subtract path. The top slice exposes the sign bit of the difference, and that bit is routed back into the comparison input of slice 0. The comparison inputs of all other slices are held low. A zero flag supports equality tests through subtraction. A signed overflow flag comes from the top slice's carries. The operation path is combinational. A single register stage with a synchronous active-high reset captures the result and both flags, so outputs follow inputs by one clock.

Top module: `rsalu_top`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of `a_i` and `b_i`, and 4'b0001 gives the bitwise OR. All results and flags appear on the outputs one rising edge after the inputs are applied.
- R2: Operation code 4'b0010 gives `a_i + b_i` modulo 2^W, and a carry out of the top bit is dropped.
- R3: Operation code 4'b0110 gives `a_i - b_i` modulo 2^W.
- R4: Operation code 4'b0111 drives result bits W-1..1 to 0 and drives bit 0 to the sign bit (bit W-1) of the raw difference `a_i - b_i`. This bit is not corrected for overflow. For example, the most negative value compared with +1 gives 0.
- R5: Operation code 4'b1100 gives the bitwise NOR of `a_i` and `b_i`.
- R6: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R7: For codes 4'b0010 and 4'b0110 (low two bits 2'b10), `ovf_o` is the signed two's-complement overflow of the add or subtract: the carry into bit W-1 XOR the carry out of it. For codes whose low two bits are not 2'b10, `ovf_o` is 0.
- R8: While `rst` is high at a rising edge, the outputs load `result_o` = 0, `zero_o` = 1 and `ovf_o` = 0, whatever the operands and code are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code: bit 3 inverts a, bit 2 inverts b and sets carry in, bits 1:0 select AND/OR/sum/less |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| result_o | output | W | Registered result |
| zero_o | output | 1 | Registered flag, high when the result is all zeros |
| ovf_o | output | 1 | Registered signed overflow flag for add and subtract |

## Verification
The bench builds the block with its default width W = 32, so the signed boundary operands 0x7FFFFFFF and 0x80000000 are exercised exactly as written. At this width the carry runs through all 32 slices, and the bench covers a carry that starts at bit 0 and travels out of the top bit. Operands near the sign boundary reach both overflow directions. They also reach the uncorrected set-less-than case, where the raw sign bit of the difference gives the wrong ordering.

// File: rtl/rsalu_pkg.sv
package rsalu_pkg;

  // Operation codes: bit 3 = invert a, bit 2 = invert b and carry in of 1,
  // bits 1:0 = slice selector
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       a_inv;
    logic       b_inv;
    logic       carry0;
    slice_sel_e sel;
    logic       arith;
  } slice_ctrl_t;

endpackage

// File: rtl/rsalu_decode.sv
module rsalu_decode
  import rsalu_pkg::*;
(
  input  logic [3:0]  op_i,
  output slice_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o.a_inv  = op_i[3];
    ctrl_o.b_inv  = op_i[2];
    ctrl_o.carry0 = op_i[2];
    ctrl_o.sel    = slice_sel_e'(op_i[1:0]);
    ctrl_o.arith  = (op_i[1:0] == SEL_SUM);
  end

endmodule

// File: rtl/rsalu_slice.sv
module rsalu_slice
  import rsalu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       less_i,
  input  logic       cin_i,
  input  logic       a_inv_i,
  input  logic       b_inv_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic aa, bb, and_b, or_b, sum_b;

  assign aa    = a_i ^ a_inv_i;
  assign bb    = b_i ^ b_inv_i;
  assign and_b = aa & bb;
  assign or_b  = aa | bb;
  // sum: odd number of ones; carry: at least two ones
  assign sum_b  = aa ^ bb ^ cin_i;
  assign cout_o = (aa & bb) | (aa & cin_i) | (bb & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = and_b;
      SEL_OR:   res_o = or_b;
      SEL_SUM:  res_o = sum_b;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      assign set_o = sum_b;
      assign ovf_o = cin_i ^ cout_o;
    end else begin : g_mid
      assign set_o = 1'b0;
      assign ovf_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rsalu_flags.sv
module rsalu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         ovf_raw_i,
  input  logic         arith_i,
  output logic         zero_o,
  output logic         ovf_o
);

  assign zero_o = ~|res_i;
  assign ovf_o  = arith_i & ovf_raw_i;

endmodule

// File: rtl/rsalu_top.sv
module rsalu_top
  import rsalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);

  localparam int TOP = W - 1;

  slice_ctrl_t    ctrl;
  logic [W-1:0]   carry_in;
  logic [W-1:0]   res_w;
  logic           set_top;
  logic           ovf_raw;
  logic           unused_cout_top;
  logic [W-2:0]   unused_set_lo;
  logic [W-2:0]   unused_ovf_lo;
  logic [W-2:0]   carry_lo;
  logic           zero_c;
  logic           ovf_c;

  rsalu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign carry_in = {carry_lo, ctrl.carry0};

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      if (i == TOP) begin : g_msb
        rsalu_slice #(.IS_TOP(1'b1)) u_slice (
          .a_i     (a_i[i]),
          .b_i     (b_i[i]),
          .less_i  (1'b0),
          .cin_i   (carry_in[i]),
          .a_inv_i (ctrl.a_inv),
          .b_inv_i (ctrl.b_inv),
          .sel_i   (ctrl.sel),
          .res_o   (res_w[i]),
          .cout_o  (unused_cout_top),
          .set_o   (set_top),
          .ovf_o   (ovf_raw)
        );
      end else begin : g_low
        rsalu_slice #(.IS_TOP(1'b0)) u_slice (
          .a_i     (a_i[i]),
          .b_i     (b_i[i]),
          .less_i  ((i == 0) ? set_top : 1'b0),
          .cin_i   (carry_in[i]),
          .a_inv_i (ctrl.a_inv),
          .b_inv_i (ctrl.b_inv),
          .sel_i   (ctrl.sel),
          .res_o   (res_w[i]),
          .cout_o  (carry_lo[i]),
          .set_o   (unused_set_lo[i]),
          .ovf_o   (unused_ovf_lo[i])
        );
      end
    end
  endgenerate

  rsalu_flags #(.W(W)) u_flags (
    .res_i     (res_w),
    .ovf_raw_i (ovf_raw),
    .arith_i   (ctrl.arith),
    .zero_o    (zero_c),
    .ovf_o     (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_w;
      zero_o   <= zero_c;
      ovf_o    <= ovf_c;
    end
  end

endmodule

// File: rtl/rsalu_chk.sv
module rsalu_chk
  import rsalu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         ovf_o
);

  initial begin
    a_w_min : assert (W >= 2);
  end

  a_r1_and: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND) |=> (result_o == ($past(a_i) & $past(b_i))));

  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (result_o == W'($past(a_i) + $past(b_i))));

  a_r3_sub: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB) |=> (result_o == W'($past(a_i) - $past(b_i))));

  a_r4_slt_upper: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLT) |=> (result_o[W-1:1] == '0));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

  a_r7_no_ovf_nonarith: assert property (@(posedge clk) disable iff (rst)
    (op_i[1:0] != 2'b10) |=> !ovf_o);

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (result_o == '0) && zero_o && !ovf_o);

endmodule

bind rsalu_top rsalu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/rsalu_top_tb.sv
module rsalu_top_tb;

  localparam int W = 32;
  localparam logic [31:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [31:0] MINN = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = 4'b0000;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] result_o;
  logic         zero_o;
  logic         ovf_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rsalu_top #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o)
  );

  function automatic logic [31:0] ref_res(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    case (op)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return d;
      4'b0111: return {31'd0, d[31]};
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s, d;
    s = a + b;
    d = a - b;
    if (op == 4'b0010) return (a[31] == b[31]) && (s[31] != a[31]);
    if (op == 4'b0110) return (a[31] != b[31]) && (d[31] != a[31]);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_i = op;
    a_i  = a;
    b_i  = b;
    @(negedge clk);
  endtask

  task automatic run_full(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    e = ref_res(op, a, b);
    apply(op, a, b);
    check(req, result_o, e);
    check({req, " zero R6"}, {31'd0, zero_o}, {31'd0, e == 32'd0});
    check({req, " ovf R7"}, {31'd0, ovf_o}, {31'd0, ref_ovf(op, a, b)});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    op_i = 4'b0010; a_i = 32'd5; b_i = 32'd6;
    @(negedge clk);
    check("R8 result", result_o, 32'd0);
    check("R8 zero", {31'd0, zero_o}, 32'd1);
    check("R8 ovf", {31'd0, ovf_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_logic();
    run_full("R1 and", 4'b0000, 32'hF0F0_1234, 32'hFF00_FF0F);
    run_full("R1 or", 4'b0001, 32'hF0F0_1234, 32'h0F00_0001);
    run_full("R1 and disjoint", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
    run_full("R5 nor", 4'b1100, 32'hF0F0_0000, 32'h0000_0F0F);
    run_full("R5 nor ones", 4'b1100, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_add();
    run_full("R2 add", 4'b0010, 32'd1234, 32'd4321);
    run_full("R2 add ripple", 4'b0010, 32'hFFFF_FFFF, 32'd1);
    run_full("R2 add pos ovf R7", 4'b0010, MAXP, 32'd1);
    run_full("R2 add neg ovf R7", 4'b0010, MINN, MINN);
  endtask

  task automatic t_sub();
    run_full("R3 sub", 4'b0110, 32'd100, 32'd58);
    run_full("R3 sub equal R6", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run_full("R3 sub neg ovf R7", 4'b0110, MINN, 32'd1);
    run_full("R3 sub pos ovf R7", 4'b0110, MAXP, 32'hFFFF_FFFF);
  endtask

  task automatic t_slt();
    run_full("R4 slt lt", 4'b0111, 32'hFFFF_FFFB, 32'd3);
    run_full("R4 slt gt", 4'b0111, 32'd9, 32'd2);
    run_full("R4 slt eq", 4'b0111, 32'd7, 32'd7);
    run_full("R4 slt min vs 1 raw", 4'b0111, MINN, 32'd1);
    run_full("R4 slt max vs -1 raw", 4'b0111, MAXP, 32'hFFFF_FFFF);
  endtask

  task automatic t_random();
    logic [3:0] ops [6];
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int k = 0; k < 300; k++) begin
      run_full("R1 R2 R3 R4 R5 random", ops[k % 6], $urandom, $urandom);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_random();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule